// File: doc/BRIEF.md
# Cascaded PWM Timer Chain

A row of identical up-counting timers sits in one synchronous clock domain. Each timer produces a pulse-width-modulated output and a one-cycle wrap pulse. The head timer counts the system clock through a programmable divider. Every later timer counts only rising edges of the wrap pulse of the timer before it, so each timer's period is a multiple of the period of the timer ahead of it. With a reload of 1 in every stage, each stage runs at half the rate of the one before.

Software programs each timer through a narrow parallel write port. The port takes a timer index, a register code and a data word, qualified by a strobe. Each timer also has its own enable line. The reload and compare values are buffered and take effect only when the counter wraps, so a running period always completes with the values it started with. Each counter value is brought out for observation.

Top module: `pwm_cascade`

## Requirements
- R1: After a synchronous active-high reset, every counter reads 0 and every PWM output and wrap pulse is low.
- R2: While enabled, the head timer's counter advances once every (P+1) system clock cycles, where P is its divider value.
- R3: A counter that receives a count tick while it is at or above its active reload value goes to 0; otherwise it increments. The period is therefore (reload+1) ticks.
- R4: The wrap pulse on `trg_o` is high for exactly the cycle in which the counter shows the 0 it has just wrapped to. It is low at all other times.
- R5: A timer other than the head produces a tick, which passes through its divider, for each rising edge of the previous timer's wrap pulse. Its counter changes two clock cycles after the pulse appears.
- R6: While enabled, a PWM output is high exactly when the counter is below the active compare value. A compare of 0 holds it low, and a compare above the reload holds it high.
- R7: Writes to register code 1 (reload) and code 2 (compare) land in buffer registers. While the timer is enabled these are copied to the active values only at a wrap. While it is disabled they are copied on every cycle.
- R8: A disabled timer holds its counter and divider count at 0, drives its PWM output low and issues no wrap pulse. A timer that follows it then stops counting.
- R9: A write with register code 3, or with a timer index at or beyond the number of timers, changes no timer.
- R10: A write to register code 0 (divider) takes effect on the next cycle. If the divider count already equals or exceeds the new value, the next input tick both wraps the divider and produces a count tick.
- R11: With reload 1 and divider 0 on the later stages, each stage's wrap period is exactly twice that of the stage before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | N_TMR | Per-timer enable |
| wr_en_i | input | 1 | Write strobe |
| wr_tmr_i | input | SEL_W | Index of the timer to write |
| wr_reg_i | input | 2 | Register code: 0 divider, 1 reload, 2 compare |
| wr_data_i | input | CNT_W | Write data |
| pwm_o | output | N_TMR | PWM output per timer |
| trg_o | output | N_TMR | One-cycle wrap pulse per timer |
| cnt_o | output | N_TMR*CNT_W | Counter values, timer i in bits [i*CNT_W +: CNT_W] |

## Verification
The chain first runs with distinct settings per stage: a divider of 1 with reload 3 on the head, and reload 1 on the followers. This separates divider errors from reload errors, because the two give different wrap intervals of 8, 16 and 32 cycles. A reload written just after a wrap must yield one old-length period and then one new-length period, which separates buffered loading from immediate loading. Writes with an invalid register code or timer index, a sudden drop of the divider value, and compare values of 0 and above the reload cover the boundary behaviour. Disabling the middle stage shows whether the stage behind it stalls. A behavioural model is compared with the counters, pulses and PWM outputs after every clock edge.

// File: rtl/tmr_chain_pkg.sv
package tmr_chain_pkg;
    typedef enum logic [1:0] {
        REG_DIV  = 2'd0,
        REG_RELD = 2'd1,
        REG_CMP  = 2'd2,
        REG_NONE = 2'd3
    } tmr_reg_e;
endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic rise_o
);
    typedef struct packed {
        logic smp;
        logic prv;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.smp = trig_i;
        st_d.prv = st_q.smp;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rise_o = st_q.smp & ~st_q.prv;

    // R5: a detected edge never lasts two cycles
    p_rise_single_r5: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             src_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [CNT_W-1:0] div_val;
        logic [CNT_W-1:0] div_cnt;
    } psc_st_t;

    psc_st_t st_d, st_q;
    logic    wrap;

    assign wrap = st_q.div_cnt >= st_q.div_val;

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.div_val = wr_data_i;
        if (!en_i) begin
            st_d.div_cnt = '0;
        end else if (src_i) begin
            if (wrap) st_d.div_cnt = '0;
            else      st_d.div_cnt = st_q.div_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign tick_o = en_i & src_i & wrap;

    // R8: a disabled divider is cleared on the following cycle
    p_div_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (st_q.div_cnt == '0));
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             wr_reld_i,
    input  logic             wr_cmp_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             upd_o,
    output logic             pwm_o
);
    typedef struct packed {
        logic [CNT_W-1:0] reld_buf;
        logic [CNT_W-1:0] cmp_buf;
        logic [CNT_W-1:0] reld_act;
        logic [CNT_W-1:0] cmp_act;
        logic [CNT_W-1:0] cnt;
        logic             upd;
    } unit_st_t;

    unit_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (wr_reld_i) st_d.reld_buf = wr_data_i;
        if (wr_cmp_i)  st_d.cmp_buf  = wr_data_i;
        if (!en_i) begin
            st_d.cnt      = '0;
            st_d.reld_act = st_q.reld_buf;
            st_d.cmp_act  = st_q.cmp_buf;
        end else if (tick_i) begin
            if (st_q.cnt >= st_q.reld_act) begin
                st_d.cnt      = '0;
                st_d.upd      = 1'b1;
                st_d.reld_act = st_q.reld_buf;
                st_d.cmp_act  = st_q.cmp_buf;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign upd_o = st_q.upd;
    assign pwm_o = en_i && (st_q.cnt < st_q.cmp_act);

    // R3: the counter never passes its active reload
    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= st_q.reld_act);

    // R4: a wrap pulse coincides with a zero count
    p_upd_at_zero_r4: assert property (@(posedge clk) disable iff (rst)
        st_q.upd |-> (st_q.cnt == '0));

    // R3: outside a wrap the counter moves only by one step
    p_cnt_step_r3: assert property (@(posedge clk) disable iff (rst)
        (en_i && $past(en_i) && !st_q.upd && (st_q.cnt != $past(st_q.cnt)))
        |-> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R7: active values stay put between wraps while running
    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(en_i) && !st_q.upd) |-> ($stable(st_q.reld_act) && $stable(st_q.cmp_act)));

    // R8: a disabled timer is quiet on the next cycle
    p_dis_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> ((st_q.cnt == '0) && !st_q.upd));
endmodule

// File: rtl/pwm_cascade.sv
module pwm_cascade
    import tmr_chain_pkg::*;
#(
    parameter int N_TMR = 3,
    parameter int CNT_W = 16,
    localparam int SEL_W = (N_TMR > 1) ? $clog2(N_TMR) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_TMR-1:0]       en_i,
    input  logic                   wr_en_i,
    input  logic [SEL_W-1:0]       wr_tmr_i,
    input  logic [1:0]             wr_reg_i,
    input  logic [CNT_W-1:0]       wr_data_i,
    output logic [N_TMR-1:0]       pwm_o,
    output logic [N_TMR-1:0]       trg_o,
    output logic [N_TMR*CNT_W-1:0] cnt_o
);
    logic [N_TMR-1:0] src;
    logic [N_TMR-1:0] tick;
    logic [N_TMR-1:0] upd;
    logic [N_TMR-1:0] hit;

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        assign hit[i] = wr_en_i && (wr_tmr_i == SEL_W'(i));

        if (i == 0) begin : g_head
            assign src[i] = 1'b1;
        end else begin : g_follow
            tmr_edge_det u_edge (
                .clk    (clk),
                .rst    (rst),
                .trig_i (upd[i-1]),
                .rise_o (src[i])
            );
        end

        tmr_prescaler #(.CNT_W(CNT_W)) u_psc (
            .clk       (clk),
            .rst       (rst),
            .en_i      (en_i[i]),
            .src_i     (src[i]),
            .wr_i      (hit[i] && (wr_reg_i == REG_DIV)),
            .wr_data_i (wr_data_i),
            .tick_o    (tick[i])
        );

        tmr_unit #(.CNT_W(CNT_W)) u_unit (
            .clk       (clk),
            .rst       (rst),
            .en_i      (en_i[i]),
            .tick_i    (tick[i]),
            .wr_reld_i (hit[i] && (wr_reg_i == REG_RELD)),
            .wr_cmp_i  (hit[i] && (wr_reg_i == REG_CMP)),
            .wr_data_i (wr_data_i),
            .cnt_o     (cnt_o[i*CNT_W +: CNT_W]),
            .upd_o     (upd[i]),
            .pwm_o     (pwm_o[i])
        );
    end

    assign trg_o = upd;

    // R9: at most one timer accepts a given write
    p_one_target_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));
endmodule

// File: tb/tb_pwm_cascade.sv
module tb_pwm_cascade;
    localparam int N  = 3;
    localparam int W  = 16;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  en = '0;
    logic          wr_en = 1'b0;
    logic [SW-1:0] wr_tmr = '0;
    logic [1:0]    wr_reg = '0;
    logic [W-1:0]  wr_data = '0;
    wire  [N-1:0]  pwm, trg;
    wire  [N*W-1:0] cnt;

    pwm_cascade #(.N_TMR(N), .CNT_W(W)) dut (
        .clk(clk), .rst(rst), .en_i(en), .wr_en_i(wr_en), .wr_tmr_i(wr_tmr),
        .wr_reg_i(wr_reg), .wr_data_i(wr_data), .pwm_o(pwm), .trg_o(trg), .cnt_o(cnt)
    );

    always #5 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    int m_dv[N], m_dc[N], m_rb[N], m_ra[N], m_cb[N], m_ca[N], m_cnt[N], m_upd[N], m_smp[N], m_prv[N];

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin : model
        int o_upd[N];
        int o_smp[N];
        int o_prv[N];
        cyc++;
        for (int i = 0; i < N; i++) begin
            o_upd[i] = m_upd[i]; o_smp[i] = m_smp[i]; o_prv[i] = m_prv[i];
        end
        for (int i = 0; i < N; i++) begin
            if (rst) begin
                m_dv[i] = 0; m_dc[i] = 0; m_rb[i] = 0; m_ra[i] = 0; m_cb[i] = 0;
                m_ca[i] = 0; m_cnt[i] = 0; m_upd[i] = 0; m_smp[i] = 0; m_prv[i] = 0;
            end else begin
                int src_v, tck, old_rb, old_cb;
                old_rb = m_rb[i]; old_cb = m_cb[i];
                src_v = (i == 0) ? 1 : (o_smp[i] && !o_prv[i]);
                m_smp[i] = (i == 0) ? 0 : o_upd[i-1];
                m_prv[i] = o_smp[i];
                m_upd[i] = 0;
                if (!en[i]) begin
                    m_dc[i] = 0; m_cnt[i] = 0; m_ra[i] = old_rb; m_ca[i] = old_cb;
                end else begin
                    tck = 0;
                    if (src_v) begin
                        if (m_dc[i] >= m_dv[i]) begin m_dc[i] = 0; tck = 1; end
                        else m_dc[i]++;
                    end
                    if (tck) begin
                        if (m_cnt[i] >= m_ra[i]) begin
                            m_cnt[i] = 0; m_upd[i] = 1; m_ra[i] = old_rb; m_ca[i] = old_cb;
                        end else m_cnt[i]++;
                    end
                end
                if (wr_en && wr_tmr == i) begin
                    if (wr_reg == 0) m_dv[i] = wr_data;
                    if (wr_reg == 1) m_rb[i] = wr_data;
                    if (wr_reg == 2) m_cb[i] = wr_data;
                end
            end
        end
    end

    // every-cycle comparison, away from the edge
    always @(posedge clk) begin
        #2;
        for (int i = 0; i < N; i++) begin
            chk("R3 R5 counter vs model", cnt[i*W +: W], m_cnt[i]);
            chk("R4 wrap pulse vs model", trg[i], m_upd[i]);
            chk("R6 pwm vs model", pwm[i], (en[i] && m_cnt[i] < m_ca[i]) ? 1 : 0);
        end
    end

    task automatic wr(input int t, input int r, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_tmr = SW'(t); wr_reg = 2'(r); wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_trg(input int s, output int t);
        do begin @(posedge clk); #2; end while (!trg[s]);
        t = cyc;
    endtask

    task automatic finish_run;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R3 act=%0d exp=0", cyc);
        finish_run();
    end

    initial begin
        int a, b, c, h, snap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 counters after reset", cnt, 0);
        chk("R1 pulses after reset", trg, 0);
        chk("R1 pwm after reset", pwm, 0);

        wr(0, 0, 1); wr(0, 1, 3); wr(0, 2, 2);
        wr(1, 0, 0); wr(1, 1, 1); wr(1, 2, 1);
        wr(2, 0, 0); wr(2, 1, 1); wr(2, 2, 1);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk("R8 disabled pulse", trg, 0);
            chk("R8 disabled pwm", pwm, 0);
        end

        @(negedge clk); en = '1;
        wait_trg(0, a); wait_trg(0, b);
        chk("R2 head period", b - a, 8);
        h = pwm[0];
        for (int k = 0; k < 7; k++) begin @(posedge clk); #2; h += pwm[0]; end
        chk("R6 head high cycles", h, 4);
        wait_trg(1, a); wait_trg(1, b);
        chk("R5 stage1 period", b - a, 16);
        wait_trg(2, a); wait_trg(2, b);
        chk("R11 stage2 period", b - a, 32);

        wait_trg(0, a);
        wr(0, 1, 7);
        wait_trg(0, b); wait_trg(0, c);
        chk("R7 period not cut", b - a, 8);
        chk("R7 new reload after wrap", c - b, 16);

        wr(0, 3, 0); wr(3, 1, 0); wr(3, 0, 0);
        wait_trg(0, a); wait_trg(0, b); wait_trg(0, c);
        chk("R9 ignored writes", c - b, 16);

        wr(0, 0, 0);
        wait_trg(0, a); wait_trg(0, b); wait_trg(0, c);
        chk("R10 new divider", c - b, 8);

        wr(0, 2, 0);
        wait_trg(0, a); wait_trg(0, b);
        h = 0;
        for (int k = 0; k < 8; k++) begin h += pwm[0]; @(posedge clk); #2; end
        chk("R6 compare zero low", h, 0);
        wr(0, 2, 9);
        wait_trg(0, a); wait_trg(0, b);
        h = 0;
        for (int k = 0; k < 8; k++) begin h += pwm[0]; @(posedge clk); #2; end
        chk("R6 compare above reload high", h, 8);

        @(negedge clk); en[1] = 1'b0;
        repeat (3) @(negedge clk);
        snap = cnt[2*W +: W];
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            chk("R8 disabled stage counter", cnt[1*W +: W], 0);
            chk("R8 disabled stage pulse", trg[1], 0);
            chk("R8 follower stalls", cnt[2*W +: W], snap);
        end
        finish_run();
    end
endmodule